// File: doc/BRIEF.md
# Leading Bit Scan Unit

This unit locates the first bit position, counting down from the most significant end of a 32-bit word, where the word disagrees with a reference pattern. The reference comes from a second operand, shifted right arithmetically by one place. If that operand has its top bit clear, the reference is zero in the top position and the scan finds the leading one. If the top bit is set, the reference is a run of ones, and the scan finds the first place where the sign pattern changes.

Each request is accepted with a valid strobe and answered exactly one clock later. A write-enable and a result appear with the answer, and the result is zero-extended to the full register width. An extension-enable input controls whether the operation exists at all. When it is low, the answer carries an unimplemented-operation trap in place of a result.

Top module: `lead_scan_unit`

## Requirements
- R1: The reference pattern is bit 31 of `scan_op` followed by bits 31 down to 1 of `scan_op`. The scanned value is `scan_word` XOR that pattern.
- R2: The reported position is the number of zero bits above the highest set bit of the scanned value. A set bit 31 gives 0, and a scanned value of 1 gives 31.
- R3: A scanned value of all zeros reports position 63, never 32.
- R4: `res_data` equals `res_pos` with bits 31 down to 6 at zero.
- R5: A request with `ext_en` low is answered with `res_trap` high, `res_wr` low and `res_data` zero. A request with `ext_en` high is answered with `res_wr` high and `res_trap` low.
- R6: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Reset, active low on `rst_n`, clears `res_valid` at once.
- R7: `res_trap` and `res_wr` are low in every cycle in which `res_valid` is low.
- R8: A written position is always in the range 0 to 31, or equal to 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| scan_word | input | 32 | Word to be scanned |
| scan_op | input | 32 | Operand that selects the reference pattern |
| ext_en | input | 1 | Operation enabled; low raises the trap |
| res_valid | output | 1 | Answer present, one cycle after the request |
| res_wr | output | 1 | Result is to be written |
| res_trap | output | 1 | Unimplemented-operation trap |
| res_pos | output | 6 | Scan position |
| res_data | output | 32 | Zero-extended scan position |

## Verification
The properties assume that `req_valid` and `ext_en` are known at every rising edge once reset is released. They also assume reset is asserted for at least one edge before the first request, so that `res_valid` starts from a defined low. The bench meets both. It holds every input at a defined value from time zero, keeps requests off during reset, and changes inputs only on falling edges. One request is overlapped with an asynchronous reset, and the bench checks that this request does not produce an answer.

// File: rtl/lead_scan_pkg.sv
package lead_scan_pkg;
  // position field must hold 0..W-1 plus a distinct "nothing found" code
  function automatic int pos_width(input int w);
    return $clog2(w) + 1;
  endfunction

  function automatic int none_code(input int pw);
    return (1 << pw) - 1;
  endfunction
endpackage

// File: rtl/lead_scan_mask.sv
module lead_scan_mask #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] op,
  output logic [W-1:0] xor_val
);
  // arithmetic shift right by one: replicate top bit into the vacated slot
  function automatic logic [W-1:0] fold_ref(input logic [W-1:0] v);
    return {v[W-1], v[W-1:1]};
  endfunction

  assign xor_val = word ^ fold_ref(op);
endmodule

// File: rtl/lead_scan_prienc.sv
module lead_scan_prienc #(
  parameter int W     = 32,
  parameter int POS_W = 6
) (
  input  logic [W-1:0]     xv,
  output logic [W-1:0]     first_hit,
  output logic             none_found,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] NOTFOUND = {POS_W{1'b1}};

  logic [W:0] seen;
  assign seen[W] = 1'b0;

  // prefix chain from the top: a bit is the first hit if nothing above it is set
  for (genvar i = W - 1; i >= 0; i--) begin : g_chain
    assign seen[i]      = seen[i+1] | xv[i];
    assign first_hit[i] = xv[i] & ~seen[i+1];
  end

  assign none_found = ~seen[0];

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (first_hit[i]) pos = pos | POS_W'(W - 1 - i);
    end
    if (none_found) pos = NOTFOUND;
  end
endmodule

// File: rtl/lead_scan_stage.sv
module lead_scan_stage #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_en,
  input  logic [POS_W-1:0] in_pos,
  output logic             q_valid,
  output logic             q_wr,
  output logic             q_trap,
  output logic [POS_W-1:0] q_pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_wr    <= 1'b0;
      q_trap  <= 1'b0;
      q_pos   <= '0;
    end else begin
      q_valid <= in_valid;
      q_wr    <= in_valid & in_en;
      q_trap  <= in_valid & ~in_en;
      if (in_valid) q_pos <= in_en ? in_pos : '0;
    end
  end
endmodule

// File: rtl/lead_scan_unit.sv
module lead_scan_unit
  import lead_scan_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [W-1:0]              scan_word,
  input  logic [W-1:0]              scan_op,
  input  logic                      ext_en,
  output logic                      res_valid,
  output logic                      res_wr,
  output logic                      res_trap,
  output logic [pos_width(W)-1:0]   res_pos,
  output logic [W-1:0]              res_data
);
  localparam int POS_W = pos_width(W);

  // named internal events for the checker
  logic [W-1:0]     xor_val;
  logic [W-1:0]     first_hit;
  logic             none_found;
  logic [POS_W-1:0] comb_pos;

  lead_scan_mask #(.W(W)) u_mask (
    .word    (scan_word),
    .op      (scan_op),
    .xor_val (xor_val)
  );

  lead_scan_prienc #(.W(W), .POS_W(POS_W)) u_enc (
    .xv         (xor_val),
    .first_hit  (first_hit),
    .none_found (none_found),
    .pos        (comb_pos)
  );

  lead_scan_stage #(.POS_W(POS_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_en    (ext_en),
    .in_pos   (comb_pos),
    .q_valid  (res_valid),
    .q_wr     (res_wr),
    .q_trap   (res_trap),
    .q_pos    (res_pos)
  );

  assign res_data = {{(W - POS_W){1'b0}}, res_pos};
endmodule

// File: rtl/lead_scan_chk.sv
module lead_scan_chk #(
  parameter int W     = 32,
  parameter int POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ext_en,
  input logic             res_valid,
  input logic             res_wr,
  input logic             res_trap,
  input logic [POS_W-1:0] res_pos,
  input logic [W-1:0]     res_data,
  input logic [W-1:0]     xor_val,
  input logic [W-1:0]     first_hit,
  input logic             none_found
);
  localparam logic [POS_W-1:0] NOTFOUND = {POS_W{1'b1}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);  // R6
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);  // R6
  AST_TRAP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_en) |=> (res_trap && !res_wr && res_data == '0));  // R5
  AST_WR_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_en) |=> (res_wr && !res_trap));  // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_trap && !res_wr));  // R7
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (res_data[W-1:POS_W] == '0 && res_data[POS_W-1:0] == res_pos));  // R4
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (int'(res_pos) < W || res_pos == NOTFOUND));  // R8
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_hit));  // R2
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    none_found |-> (xor_val == '0));  // R3
  AST_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_en && none_found) |=> (res_pos == NOTFOUND));  // R3
endmodule

bind lead_scan_unit lead_scan_chk #(.W(W), .POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .ext_en     (ext_en),
  .res_valid  (res_valid),
  .res_wr     (res_wr),
  .res_trap   (res_trap),
  .res_pos    (res_pos),
  .res_data   (res_data),
  .xor_val    (xor_val),
  .first_hit  (first_hit),
  .none_found (none_found)
);

// File: tb/tb_lead_scan_unit.sv
module tb_lead_scan_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] scan_word = '0;
  logic [31:0] scan_op = '0;
  logic        ext_en = 1'b0;
  logic        res_valid, res_wr, res_trap;
  logic [5:0]  res_pos;
  logic [31:0] res_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lead_scan_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .scan_word (scan_word),
    .scan_op   (scan_op),
    .ext_en    (ext_en),
    .res_valid (res_valid),
    .res_wr    (res_wr),
    .res_trap  (res_trap),
    .res_pos   (res_pos),
    .res_data  (res_data)
  );

  typedef struct {
    logic       v;
    logic       trap;
    logic [5:0] pos;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // walk down from the top bit; an empty value maps to the 63 code
  function automatic logic [5:0] ref_pos(input logic [31:0] w, input logic [31:0] op);
    logic [31:0] m;
    logic [31:0] x;
    m = 32'($signed(op) >>> 1);
    x = w ^ m;
    for (int n = 0; n < 32; n++) begin
      if (x[31-n]) return 6'(n);
    end
    return 6'd63;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] op,
                       input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v;
    scan_word = w;
    scan_op   = op;
    ext_en    = en;
    e.v    = v;
    e.trap = v & ~en;
    e.pos  = (v && en) ? ref_pos(w, op) : 6'd0;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: the answer to an item pushed before an edge is visible just after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check("R6 valid", 32'(res_valid), 32'(e.v));
        if (e.v) begin
          check("R5 trap", 32'(res_trap), 32'(e.trap));
          check("R5 wr", 32'(res_wr), 32'(!e.trap));
          check(e.tag, 32'(res_pos), 32'(e.pos));
          check("R4 data", res_data, {26'd0, e.pos});
          if (!e.trap) check("R8 range", 32'(res_pos < 6'd32 || res_pos == 6'd63), 32'd1);
        end else begin
          check("R7 quiet", 32'({res_trap, res_wr}), 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R6 watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // reset state
    check("R6 reset valid", 32'(res_valid), 32'd0);
    check("R7 reset flags", 32'({res_trap, res_wr}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(1, 32'h8000_0000, 32'h0, 1, "R2 top bit");
    drive(1, 32'h0000_0001, 32'h0, 1, "R2 low bit");
    drive(1, 32'h0000_0000, 32'h0, 1, "R3 empty");
    drive(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R3 sign all ones");
    drive(1, 32'hFFFF_0000, 32'h8000_0000, 1, "R1 sign extend");   // expect 2
    drive(1, 32'h0000_0001, 32'h0000_0002, 1, "R1 shift cancels"); // expect 63
    drive(1, 32'h0000_0000, 32'h0000_0003, 1, "R1 shift drops lsb"); // expect 31
    drive(0, 32'hDEAD_BEEF, 32'h0, 1, "R6 idle");
    drive(1, 32'h8000_0000, 32'h0, 0, "R5 disabled");
    drive(1, 32'h0000_0000, 32'h0, 0, "R5 disabled empty");
    drive(0, 32'h0, 32'h0, 0, "R7 idle");
    // every position: flip one bit against the reference (R2)
    for (int k = 0; k < 32; k++) begin
      drive(1, 32'($signed(32'hC000_0000) >>> 1) ^ (32'h1 << k), 32'hC000_0000, 1, "R2 walk");
    end
    for (int k = 0; k < 150; k++) begin
      logic [31:0] w;
      logic [31:0] op;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      w  = lf >> (lf[4:0]);
      op = {lf[7], lf[30:0]};
      drive(lf[9:8] != 2'b00, w, op, lf[12:10] != 3'b000, "R2 mixed");
    end
    drive(0, 32'h0, 32'h0, 1, "R6 tail");
    wait (sb.size() == 0);
    @(negedge clk);

    // request overlapped with reset must not produce an answer (R6)
    req_valid = 1'b1;
    ext_en    = 1'b1;
    rst_n     = 1'b0;
    @(posedge clk);
    #2;
    check("R6 reset clears", 32'(res_valid), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n     = 1'b1;
    @(negedge clk);
    check("R6 after reset", 32'(res_valid), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule